// File: doc/BRIEF.md
# Serial-Bus Register Pointer Slave

This block is a two-wire serial-bus slave that lets a host reach a small register file through a command-code pointer. It oversamples the bus clock and data lines with the system clock and recognises START, repeated START and STOP. It answers one fixed 7-bit device address, and it drives the data line only through an open-drain enable. The first byte after a write-direction address byte is always the command code. That code is kept in a pointer register, and the pointer selects the register-file entry for every later data byte.

A per-register width map marks each entry as byte-wide or word-wide, and this sets how many bytes a transfer carries. A send-byte transaction moves only the command code. A write carries the command code and then one data byte for a byte register, or two data bytes (low byte first) for a word register. A read consists of a write of the command code, a repeated START, and an address byte in the read direction. The slave then returns one byte, or two bytes with the low byte first. The pointer keeps its value between transactions, so a read may also start directly with the read-direction address byte.

The register file itself sits outside the block. The block presents an address, reads 16-bit data combinationally, and issues single-cycle byte writes with byte enables.

Top module: `smb_regport_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and `reg_we` is 0.
- R2: The slave acknowledges an address byte whose upper seven bits equal DEV_ADDR (default 0x20, so 0x40 for write and 0x41 for read; bit 0 = 1 means read). Any other address byte is not acknowledged. After such a byte the slave drives nothing and writes nothing until the next START.
- R3: The slave acknowledges the first byte after a write-direction address and stores it in the pointer. `reg_addr` equals the pointer's low AW bits.
- R4: A send-byte transaction (address, command, STOP) produces no `reg_we` pulse.
- R5: The slave acknowledges a data byte that fits the selected register's length. Each such byte causes exactly one single-cycle `reg_we` pulse, and the byte is placed on both halves of `reg_wdata`.
- R6: In a write, the first data byte uses `reg_be`=01 (low byte) and the second uses `reg_be`=10 (high byte). The second data byte is accepted only for a word register. A data byte beyond the register's length is not acknowledged and not written.
- R7: After a repeated START and a read-direction address, the slave sends `reg_rdata[7:0]` MSB first from the register the pointer selects. A read with no new command code uses the pointer from the previous transaction.
- R8: In a read of a word register, the slave sends `reg_rdata[15:8]` after the low byte if the master acknowledges. After a master NACK, or after the last byte of the register's length, the slave releases SDA, so the line reads 0xFF.
- R9: `sda_oe` changes only while SCL is low.
- R10: Bit i of WORD_MAP set marks register i as word-wide (default 8'hF0: registers 4 to 7 are word-wide, 0 to 3 byte-wide).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | 1 pulls the data line low |
| reg_addr | output | AW | Register index (pointer low bits) |
| reg_rdata | input | 16 | Read data of the indexed register |
| reg_we | output | 1 | Single-cycle byte write strobe |
| reg_be | output | 2 | Byte enable: 01 low byte, 10 high byte |
| reg_wdata | output | 16 | Written byte copied onto both halves |

## Verification
The bench builds the block with its defaults: device address 0x20, eight registers, and width map 8'hF0. This places byte-wide and word-wide entries side by side. With these values, random command codes exercise both transfer lengths. The NACK on an over-length byte and the released second read byte are reached on the byte registers, and the two-byte write and read orderings are reached on the word registers. A bus clock of 32 system cycles per bit leaves room for the synchronizer and edge-detect latency ahead of every sample point.

// File: rtl/smb_regport_pkg.sv
package smb_regport_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_WDATA,
        ST_READ,
        ST_RACK,
        ST_SKIP
    } smb_state_e;

    typedef struct packed {
        smb_state_e st;
        logic [3:0] cnt;
        logic       in_ack;
        logic [7:0] shift;
        logic [7:0] ptr;
        logic [1:0] idx;
        logic [7:0] txsh;
        logic       mack;
        logic       oe;
        logic       we;
        logic [1:0] be;
        logic [7:0] wbyte;
    } smb_regs_t;

endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_prev_q;
    logic sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/smb_regport_slave.sv
module smb_regport_slave
    import smb_regport_pkg::*;
#(
    parameter logic [6:0]          DEV_ADDR    = 7'h20,
    parameter int                  NUM_REGS    = 8,
    parameter logic [NUM_REGS-1:0] WORD_MAP    = 8'hF0,
    parameter int                  SYNC_STAGES = 2,
    localparam int                 AW          = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic [AW-1:0] reg_addr,
    input  logic [15:0]   reg_rdata,
    output logic          reg_we,
    output logic [1:0]    reg_be,
    output logic [15:0]   reg_wdata
);
    logic [1:0] bus_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;
    logic       is_word;
    smb_regs_t  r_d, r_q;

    smb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({scl_i, sda_i}),
        .dout (bus_s)
    );
    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    smb_bus_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    assign is_word = WORD_MAP[r_q.ptr[AW-1:0]];

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        if (start_det) begin
            r_d.st     = ST_ADDR;
            r_d.cnt    = '0;
            r_d.in_ack = 1'b0;
            r_d.oe     = 1'b0;
        end else if (stop_det) begin
            r_d.st     = ST_IDLE;
            r_d.in_ack = 1'b0;
            r_d.oe     = 1'b0;
        end else if (r_q.in_ack) begin
            // ninth clock ends: release, or put the first read bit on the line
            if (scl_fall) begin
                r_d.in_ack = 1'b0;
                r_d.cnt    = '0;
                r_d.oe     = (r_q.st == ST_READ) ? ~r_q.txsh[7] : 1'b0;
            end
        end else begin
            case (r_q.st)
                ST_ADDR, ST_CMD, ST_WDATA: begin
                    if (scl_rise && r_q.cnt != 4'd8) begin
                        r_d.shift = {r_q.shift[6:0], sda_s};
                        r_d.cnt   = r_q.cnt + 4'd1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        r_d.st = ST_SKIP;
                        if (r_q.st == ST_ADDR) begin
                            if (r_q.shift[7:1] == DEV_ADDR) begin
                                r_d.in_ack = 1'b1;
                                r_d.oe     = 1'b1;
                                r_d.idx    = '0;
                                if (r_q.shift[0]) begin
                                    r_d.st   = ST_READ;
                                    r_d.txsh = reg_rdata[7:0];
                                end else begin
                                    r_d.st = ST_CMD;
                                end
                            end
                        end else if (r_q.st == ST_CMD) begin
                            r_d.ptr    = r_q.shift;
                            r_d.in_ack = 1'b1;
                            r_d.oe     = 1'b1;
                            r_d.idx    = '0;
                            r_d.st     = ST_WDATA;
                        end else if (r_q.idx == 2'd0 || (r_q.idx == 2'd1 && is_word)) begin
                            r_d.in_ack = 1'b1;
                            r_d.oe     = 1'b1;
                            r_d.we     = 1'b1;
                            r_d.be     = (r_q.idx == 2'd0) ? 2'b01 : 2'b10;
                            r_d.wbyte  = r_q.shift;
                            r_d.idx    = r_q.idx + 2'd1;
                            r_d.st     = ST_WDATA;
                        end
                    end
                end
                ST_READ: begin
                    if (scl_rise && r_q.cnt != 4'd8) begin
                        r_d.cnt = r_q.cnt + 4'd1;
                    end else if (scl_fall && r_q.cnt == 4'd8) begin
                        r_d.oe   = 1'b0;
                        r_d.mack = 1'b0;
                        r_d.st   = ST_RACK;
                    end else if (scl_fall && r_q.cnt != 4'd0) begin
                        r_d.txsh = {r_q.txsh[6:0], 1'b0};
                        r_d.oe   = ~r_q.txsh[6];
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        r_d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (r_q.mack && r_q.idx == 2'd0 && is_word) begin
                            r_d.idx  = 2'd1;
                            r_d.txsh = reg_rdata[15:8];
                            r_d.oe   = ~reg_rdata[15];
                            r_d.cnt  = '0;
                            r_d.st   = ST_READ;
                        end else begin
                            r_d.st = ST_SKIP;
                        end
                    end
                end
                default: r_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe    = r_q.oe;
    assign reg_addr  = r_q.ptr[AW-1:0];
    assign reg_we    = r_q.we;
    assign reg_be    = r_q.be;
    assign reg_wdata = {r_q.wbyte, r_q.wbyte};
endmodule

// File: rtl/smb_regport_checker.sv
module smb_regport_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       reg_we,
    input logic [1:0] reg_be
);
    AST_WE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R5
    AST_WE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> sda_oe); // R5
    AST_BE_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($countones(reg_be) == 1)); // R6
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i); // R9
    AST_WE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> !scl_i); // R5
endmodule

bind smb_regport_slave smb_regport_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_oe(sda_oe),
    .reg_we(reg_we),
    .reg_be(reg_be)
);

// File: tb/tb_smb_regport_slave.sv
module tb_smb_regport_slave;
    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [2:0]  reg_addr;
    logic [15:0] reg_rdata;
    logic        reg_we;
    logic [1:0]  reg_be;
    logic [15:0] reg_wdata;

    logic [15:0] mem     [8];
    logic [15:0] exp_mem [8];
    int          tests = 0;
    int          fails = 0;
    int          we_count = 0;
    int          oe_high_viol = 0;
    logic        oe_prev = 1'b0;

    always #10 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    smb_regport_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .reg_rdata(reg_rdata),
        .reg_we   (reg_we),
        .reg_be   (reg_be),
        .reg_wdata(reg_wdata)
    );

    // external register file model
    always_ff @(posedge clk) begin
        if (reg_we) begin
            if (reg_be[0]) mem[reg_addr][7:0]  <= reg_wdata[7:0];
            if (reg_be[1]) mem[reg_addr][15:8] <= reg_wdata[15:8];
            we_count <= we_count + 1;
        end
    end

    // R9 monitor
    always @(negedge clk) begin
        if (rst_n && sda_oe !== oe_prev && scl) oe_high_viol++;
        oe_prev = sda_oe;
    end

    function automatic bit word_reg(input logic [7:0] cmd);
        return cmd[2];
    endfunction

    function automatic logic [7:0] exp_byte(input logic [7:0] cmd, input int k);
        return (k == 0) ? exp_mem[cmd[2:0]][7:0] : exp_mem[cmd[2:0]][15:8];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q);
        scl = 1'b1; wq(Q);
        m_sda = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq(Q);
            scl = 1'b1; wq(2*Q);
            scl = 1'b0; wq(Q);
        end
        m_sda = 1'b1; wq(Q);
        scl = 1'b1; wq(Q);
        acked = ~sda_line; wq(Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq(Q);
            scl = 1'b1; wq(Q);
            b[i] = sda_line; wq(Q);
            scl = 1'b0; wq(Q);
        end
        m_sda = ~give_ack; wq(Q);
        scl = 1'b1; wq(2*Q);
        scl = 1'b0; wq(Q);
    endtask

    task automatic do_send(input logic [7:0] cmd);
        bit a;
        int w0;
        w0 = we_count;
        bus_start();
        send_byte(8'h40, a); chk("R2 addr ack", a, 1);
        send_byte(cmd, a);   chk("R3 cmd ack", a, 1);
        bus_stop();
        chk("R4 no write", we_count - w0, 0);
        chk("R3 pointer", reg_addr, cmd[2:0]);
    endtask

    task automatic do_write(input logic [7:0] cmd, input int nd, input logic [15:0] dat);
        bit a;
        int w0;
        int len;
        w0 = we_count;
        len = word_reg(cmd) ? 2 : 1;
        bus_start();
        send_byte(8'h40, a); chk("R2 addr ack", a, 1);
        send_byte(cmd, a);   chk("R3 cmd ack", a, 1);
        for (int k = 0; k < nd; k++) begin
            send_byte(k == 0 ? dat[7:0] : dat[15:8], a);
            chk((k < len) ? "R5 data ack" : "R6 extra nack", a, (k < len) ? 1 : 0);
            if (k == 0) exp_mem[cmd[2:0]][7:0] = dat[7:0];
            if (k == 1 && len == 2) exp_mem[cmd[2:0]][15:8] = dat[15:8];
        end
        bus_stop();
        chk("R5 write count", we_count - w0, (nd < len) ? nd : len);
        chk("R6 R10 reg content", mem[cmd[2:0]], exp_mem[cmd[2:0]]);
    endtask

    task automatic do_read(input bit with_cmd, input logic [7:0] cmd, input int nb);
        bit a;
        logic [7:0] b;
        int len;
        len = word_reg(cmd) ? 2 : 1;
        bus_start();
        if (with_cmd) begin
            send_byte(8'h40, a); chk("R2 addr ack", a, 1);
            send_byte(cmd, a);   chk("R3 cmd ack", a, 1);
            bus_start();
        end
        send_byte(8'h41, a); chk("R2 read addr ack", a, 1);
        for (int k = 0; k < nb; k++) begin
            recv_byte(k < nb - 1, b);
            if (k < len) chk((k == 0) ? "R7 low byte" : "R8 R10 high byte", b, exp_byte(cmd, k));
            else chk("R8 released", b, 8'hFF);
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit a;
        logic [7:0] cmd;
        int w0;
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) begin
            mem[i] = 16'h1111 * i[15:0] + 16'h0A05;
            exp_mem[i] = mem[i];
        end
        wq(5);
        chk("R1 sda_oe reset", sda_oe, 0);
        chk("R1 reg_we reset", reg_we, 0);
        rst_n = 1'b1;
        wq(5);
        chk("R1 sda_oe idle", sda_oe, 0);

        // wrong address: no ack, no drive, no write
        w0 = we_count;
        bus_start();
        send_byte(8'h42, a); chk("R2 wrong addr nack", a, 0);
        send_byte(8'h00, a); chk("R2 ignored byte", a, 0);
        send_byte(8'h5A, a); chk("R2 ignored data", a, 0);
        bus_stop();
        chk("R2 no write", we_count - w0, 0);

        // directed corners
        do_send(8'h05);
        do_read(1'b0, 8'h05, 2);          // R7 pointer persists, word read
        do_write(8'h02, 2, 16'hBEC3);     // byte reg: second byte nacked
        do_write(8'h06, 3, 16'h7E81);     // word reg: third byte nacked
        do_read(1'b1, 8'h06, 2);
        do_read(1'b1, 8'h06, 1);          // R8 NACK after low byte
        do_read(1'b1, 8'h01, 2);          // R8 byte reg: second byte released
        do_write(8'h04, 1, 16'h0033);     // word reg, only low byte

        // random mix
        for (int t = 0; t < 50; t++) begin
            cmd = 8'($urandom_range(0, 7));
            case ($urandom_range(0, 2))
                0: do_send(cmd);
                1: do_write(cmd, $urandom_range(1, 3), 16'($urandom));
                default: do_read(1'b1, cmd, $urandom_range(1, 2));
            endcase
        end

        chk("R9 oe changes with SCL low", oe_high_viol, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule